// File: doc/BRIEF.md
# Channel Event Interrupt Aggregator

This block gathers completion events from a bank of DMA channels and folds them into one level-sensitive interrupt line. Every channel can raise three kinds of event, each as a single-cycle pulse: the first half of a transfer has gone through, one descriptor has finished, and the whole descriptor chain has finished. Each event sets a sticky status bit. Software reads these bits through a small register port and clears them by writing ones.

A matching set of enable bits decides which status bits may drive the interrupt. Each channel gets a four-bit slot, and eight slots pack into one 32-bit word, so channel N lives in word N/8 at bit (N%8)*4. Enable words start at offset 0x00 and status words start at offset 0x10. A read-only word at offset 0x30 shows one busy flag per channel, taken straight from the channels.

Top module: `dma_irq_aggr`

## Requirements
- R1: After reset, every enable and status bit reads 0 and `irq` is low.
- R2: A pulse on `ev_half[n]`, `ev_pkg[n]` or `ev_queue[n]` sets bit 0, 1 or 2 respectively of channel n's slot. The slot is in the status word at 0x10 + 4*(n/8), at bit offset (n%8)*4. The bit can be read at the clock edge after the pulse, whatever the enable bits hold.
- R3: A write to a status word clears exactly the bits written as 1. Bits written as 0 keep their value.
- R4: When an event pulse and a clear of the same status bit fall in the same cycle, the bit stays set.
- R5: The enable words at 0x00 + 4*(n/8) are read/write and use the same slot layout as the status words.
- R6: `irq` is a register. It equals the OR over all channels and event kinds of (status AND enable) as that term stood one clock earlier. It rises and falls one edge after the status or enable change.
- R7: Writing zero to every enable word drives `irq` low while the status bits stay set.
- R8: Bit 3 of every slot, in both enable and status words, always reads 0 and ignores writes.
- R9: The word at 0x30 reads `chan_busy` in its low bits and zero above them. Writes to it change nothing.
- R10: Addresses outside the enable, status and busy words read 0, and writes to them leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W (8) | Byte address for register read and write |
| reg_wr | input | 1 | Write strobe; the write takes effect at the next rising edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ev_half | input | NUM_CH (16) | Half-transfer event pulses, one per channel |
| ev_pkg | input | NUM_CH (16) | Descriptor-done event pulses |
| ev_queue | input | NUM_CH (16) | Chain-done event pulses |
| chan_busy | input | NUM_CH (16) | Per-channel busy flags |
| irq | output | 1 | Combined interrupt, registered level |

## Verification
Events are driven on channels 0, 9 and 15, one for each kind. This shows that the word index, slot offset and kind bit are mapped separately, and that a status bit sets with its enable both off and on. Clear writes are tested two ways: mixed one/zero patterns, and one pattern that lands in the same cycle as a pulse on a bit being cleared. These tell a true write-one-to-clear apart from a plain overwrite, and set priority apart from clear priority. All-ones writes check that the reserved slot bits stay zero. Writes to unmapped addresses and to the busy word are followed by read-back of every writable word, so a stray decode would show up.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
   localparam int REG_W      = 32;
   localparam int SLOT_W     = 4;
   localparam int EV_KINDS   = 3;
   localparam int CH_PER_REG = REG_W / SLOT_W;
   localparam int OFS_EN     = 'h00;
   localparam int OFS_ST     = 'h10;
   localparam int OFS_BUSY   = 'h30;
   localparam int MAX_REGS   = (OFS_ST - OFS_EN) / 4;

   typedef enum logic [1:0] {
      EV_HALF  = 2'd0,
      EV_PKG   = 2'd1,
      EV_QUEUE = 2'd2
   } ev_kind_e;

   typedef struct packed {
      logic                en_we;
      logic                st_w1c;
      logic [EV_KINDS-1:0] wbits;
   } slot_ctl_t;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
   import dma_irq_pkg::*;
#(
   parameter int NUM_REG = 2,
   parameter int ADDR_W  = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [NUM_REG-1:0] en_sel,
   output logic [NUM_REG-1:0] st_sel,
   output logic               busy_sel
);
   for (genvar k = 0; k < NUM_REG; k++) begin : g_word
      assign en_sel[k] = (addr == ADDR_W'(OFS_EN + 4*k));
      assign st_sel[k] = (addr == ADDR_W'(OFS_ST + 4*k));
   end
   assign busy_sel = (addr == ADDR_W'(OFS_BUSY));
endmodule

// File: rtl/irq_chan_slot.sv
module irq_chan_slot
   import dma_irq_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  slot_ctl_t           ctl,
   input  logic [EV_KINDS-1:0] ev,
   output logic [EV_KINDS-1:0] en_q,
   output logic [EV_KINDS-1:0] st_q
);
   logic [EV_KINDS-1:0] clr_mask;

   assign clr_mask = ctl.st_w1c ? ctl.wbits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
         st_q <= '0;
      end else begin
         if (ctl.en_we) en_q <= ctl.wbits;
         // a pulse in the clearing cycle keeps the bit set
         st_q <= (st_q & ~clr_mask) | ev;
      end
   end
endmodule

// File: rtl/irq_line_reduce.sv
module irq_line_reduce #(
   parameter int W       = 48,
   parameter bit OUT_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] pend,
   output logic         irq
);
   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= |pend;
      end
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign irq = |pend;
   end
endmodule

// File: rtl/dma_irq_aggr.sv
module dma_irq_aggr
   import dma_irq_pkg::*;
#(
   parameter int NUM_CH  = 16,
   parameter int ADDR_W  = 8,
   parameter bit OUT_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  reg_addr,
   input  logic               reg_wr,
   input  logic [REG_W-1:0]   reg_wdata,
   output logic [REG_W-1:0]   reg_rdata,
   input  logic [NUM_CH-1:0]  ev_half,
   input  logic [NUM_CH-1:0]  ev_pkg,
   input  logic [NUM_CH-1:0]  ev_queue,
   input  logic [NUM_CH-1:0]  chan_busy,
   output logic               irq
);
   localparam int NUM_REG = (NUM_CH + CH_PER_REG - 1) / CH_PER_REG;
   localparam int FLAT_W  = NUM_CH * EV_KINDS;

   if (NUM_CH < 1 || NUM_REG > MAX_REGS || NUM_CH > REG_W) begin : g_bad_ch
      $error("dma_irq_aggr: NUM_CH out of range");
   end
   if (ADDR_W < 6) begin : g_bad_addr
      $error("dma_irq_aggr: ADDR_W too narrow for register map");
   end

   logic [NUM_REG-1:0] en_sel, st_sel;
   logic               busy_sel;
   logic [FLAT_W-1:0]  en_flat, st_flat, ev_flat;
   logic [REG_W-1:0]   en_word [NUM_REG];
   logic [REG_W-1:0]   st_word [NUM_REG];

   irq_reg_decode #(.NUM_REG(NUM_REG), .ADDR_W(ADDR_W)) u_dec (
      .addr     (reg_addr),
      .en_sel   (en_sel),
      .st_sel   (st_sel),
      .busy_sel (busy_sel)
   );

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      localparam int R = ch / CH_PER_REG;
      localparam int S = ch % CH_PER_REG;
      slot_ctl_t ctl;

      assign ctl.en_we  = reg_wr & en_sel[R];
      assign ctl.st_w1c = reg_wr & st_sel[R];
      assign ctl.wbits  = reg_wdata[S*SLOT_W +: EV_KINDS];
      assign ev_flat[ch*EV_KINDS +: EV_KINDS] = {ev_queue[ch], ev_pkg[ch], ev_half[ch]};

      irq_chan_slot u_slot (
         .clk   (clk),
         .rst_n (rst_n),
         .ctl   (ctl),
         .ev    (ev_flat[ch*EV_KINDS +: EV_KINDS]),
         .en_q  (en_flat[ch*EV_KINDS +: EV_KINDS]),
         .st_q  (st_flat[ch*EV_KINDS +: EV_KINDS])
      );
   end

   always_comb begin
      for (int k = 0; k < NUM_REG; k++) begin
         en_word[k] = '0;
         st_word[k] = '0;
      end
      for (int ch = 0; ch < NUM_CH; ch++) begin
         en_word[ch / CH_PER_REG][(ch % CH_PER_REG)*SLOT_W +: EV_KINDS] =
            en_flat[ch*EV_KINDS +: EV_KINDS];
         st_word[ch / CH_PER_REG][(ch % CH_PER_REG)*SLOT_W +: EV_KINDS] =
            st_flat[ch*EV_KINDS +: EV_KINDS];
      end
   end

   always_comb begin
      reg_rdata = '0;
      for (int k = 0; k < NUM_REG; k++) begin
         if (en_sel[k]) reg_rdata = en_word[k];
         if (st_sel[k]) reg_rdata = st_word[k];
      end
      if (busy_sel) reg_rdata = REG_W'(chan_busy);
   end

   irq_line_reduce #(.W(FLAT_W), .OUT_REG(OUT_REG)) u_red (
      .clk   (clk),
      .rst_n (rst_n),
      .pend  (st_flat & en_flat),
      .irq   (irq)
   );
endmodule

// File: rtl/dma_irq_aggr_chk.sv
module dma_irq_aggr_chk
   import dma_irq_pkg::*;
#(
   parameter int NUM_CH  = 16,
   parameter int ADDR_W  = 8,
   parameter bit OUT_REG = 1'b1
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic [ADDR_W-1:0]          reg_addr,
   input logic                       reg_wr,
   input logic [REG_W-1:0]           reg_wdata,
   input logic [REG_W-1:0]           reg_rdata,
   input logic [NUM_CH-1:0]          chan_busy,
   input logic                       irq,
   input logic [NUM_CH*EV_KINDS-1:0] st_flat,
   input logic [NUM_CH*EV_KINDS-1:0] en_flat,
   input logic [NUM_CH*EV_KINDS-1:0] ev_flat
);
   localparam int NUM_REG = (NUM_CH + CH_PER_REG - 1) / CH_PER_REG;
   localparam int FLAT_W  = NUM_CH * EV_KINDS;
   localparam logic [REG_W-1:0] RSV_MASK = {CH_PER_REG{4'b1000}};

   logic              armed;
   logic [FLAT_W-1:0] clr_vec;
   logic              in_win;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_clr
      for (genvar t = 0; t < EV_KINDS; t++) begin : g_kind
         assign clr_vec[ch*EV_KINDS + t] = reg_wr &&
            (reg_addr == ADDR_W'(OFS_ST + 4*(ch / CH_PER_REG))) &&
            reg_wdata[(ch % CH_PER_REG)*SLOT_W + t];
      end
   end

   assign in_win = (reg_addr < ADDR_W'(OFS_EN + 4*NUM_REG)) ||
                   ((reg_addr >= ADDR_W'(OFS_ST)) && (reg_addr < ADDR_W'(OFS_ST + 4*NUM_REG)));

   // R2: every pulsed event is visible in status on the next edge
   p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> ((st_flat & $past(ev_flat)) == $past(ev_flat)));

   // R3: a status bit only falls after a write-one-to-clear on that bit
   p_clear_only_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> ((~st_flat & $past(st_flat) & ~$past(clr_vec)) == '0));

   // R8: reserved slot bit reads zero
   p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_win |-> ((reg_rdata & RSV_MASK) == '0));

   // R9: busy word mirrors the busy inputs
   p_busy_mirror_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == ADDR_W'(OFS_BUSY)) |-> (reg_rdata == REG_W'(chan_busy)));

   if (OUT_REG) begin : g_irq_chk
      // R6: registered combination of status and enable
      p_irq_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
         armed |-> (irq == $past(|(st_flat & en_flat))));
   end
endmodule

bind dma_irq_aggr dma_irq_aggr_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .OUT_REG(OUT_REG)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_addr  (reg_addr),
   .reg_wr    (reg_wr),
   .reg_wdata (reg_wdata),
   .reg_rdata (reg_rdata),
   .chan_busy (chan_busy),
   .irq       (irq),
   .st_flat   (st_flat),
   .en_flat   (en_flat),
   .ev_flat   (ev_flat)
);

// File: tb/dma_irq_aggr_tb_top.sv
`timescale 1ns/1ps
module dma_irq_aggr_tb_top;
   localparam int NCH = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [NCH-1:0] ev_half = '0, ev_pkg = '0, ev_queue = '0, chan_busy = '0;
   logic        irq;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dma_irq_aggr dut_i (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_half(ev_half),
      .ev_pkg(ev_pkg), .ev_queue(ev_queue), .chan_busy(chan_busy), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic pulse(input int kind, input int ch);
      @(negedge clk);
      case (kind)
         0: ev_half[ch] = 1'b1;
         1: ev_pkg[ch] = 1'b1;
         default: ev_queue[ch] = 1'b1;
      endcase
      @(negedge clk);
      ev_half = '0; ev_pkg = '0; ev_queue = '0;
   endtask

   task automatic clear_all();
      wr(8'h10, 32'hFFFF_FFFF);
      wr(8'h14, 32'hFFFF_FFFF);
      wr(8'h00, 32'h0);
      wr(8'h04, 32'h0);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(8'h00, d); chk("R1 en0", d, 0);
      rd(8'h04, d); chk("R1 en1", d, 0);
      rd(8'h10, d); chk("R1 st0", d, 0);
      rd(8'h14, d); chk("R1 st1", d, 0);
      chk("R1 irq", {31'b0, irq}, 0);
   endtask

   task automatic t_events();
      logic [31:0] d;
      pulse(1, 0);
      rd(8'h10, d); chk("R2 ch0 pkg", d, 32'h0000_0002);
      pulse(0, 9);
      rd(8'h14, d); chk("R2 ch9 half", d, 32'h0000_0010);
      pulse(2, 15);
      rd(8'h14, d); chk("R2 ch15 queue", d, 32'h4000_0010);
      chk("R2 irq stays low when disabled", {31'b0, irq}, 0);
      clear_all();
   endtask

   task automatic t_w1c();
      logic [31:0] d;
      pulse(0, 2); pulse(1, 2); pulse(2, 2); pulse(0, 3);
      rd(8'h10, d); chk("R3 before clear", d, 32'h0000_1700);
      wr(8'h10, 32'h0000_1200);
      rd(8'h10, d); chk("R3 partial clear", d, 32'h0000_0500);
      wr(8'h10, 32'h0000_0000);
      rd(8'h10, d); chk("R3 zero write keeps", d, 32'h0000_0500);
      clear_all();
   endtask

   task automatic t_set_wins();
      logic [31:0] d;
      pulse(0, 3);
      @(negedge clk);
      ev_pkg[3] = 1'b1;
      reg_addr = 8'h10; reg_wr = 1'b1; reg_wdata = 32'h0000_3000;
      @(negedge clk);
      reg_wr = 1'b0; ev_pkg = '0;
      rd(8'h10, d); chk("R4 set beats clear", d, 32'h0000_2000);
      clear_all();
   endtask

   task automatic t_enable_rw();
      logic [31:0] d;
      wr(8'h00, 32'h0000_0421);
      wr(8'h04, 32'h7000_0003);
      rd(8'h00, d); chk("R5 en0 readback", d, 32'h0000_0421);
      rd(8'h04, d); chk("R5 en1 readback", d, 32'h7000_0003);
      wr(8'h00, 32'hFFFF_FFFF);
      rd(8'h00, d); chk("R8 en0 reserved bits", d, 32'h7777_7777);
      pulse(0, 8); pulse(1, 8); pulse(2, 8);
      wr(8'h14, 32'h0000_0008);
      rd(8'h14, d); chk("R8 reserved clear harmless", d, 32'h0000_0007);
      clear_all();
   endtask

   task automatic t_irq();
      logic [31:0] d;
      wr(8'h04, 32'h0400_0000);
      pulse(2, 14);
      chk("R6 irq low at status edge", {31'b0, irq}, 0);
      @(negedge clk);
      chk("R6 irq high one edge later", {31'b0, irq}, 1);
      wr(8'h14, 32'h0400_0000);
      chk("R6 irq still high at clear edge", {31'b0, irq}, 1);
      @(negedge clk);
      chk("R6 irq low after clear", {31'b0, irq}, 0);
      pulse(0, 5);
      @(negedge clk);
      chk("R6 other bit not enabled", {31'b0, irq}, 0);
      wr(8'h00, 32'h0010_0000);
      @(negedge clk);
      chk("R6 late enable raises", {31'b0, irq}, 1);
      // R7: mask everything
      wr(8'h00, 32'h0);
      wr(8'h04, 32'h0);
      @(negedge clk);
      chk("R7 irq masked", {31'b0, irq}, 0);
      rd(8'h10, d); chk("R7 status kept", d, 32'h0010_0000);
      clear_all();
   endtask

   task automatic t_busy();
      logic [31:0] d;
      chan_busy = 16'hA5C3;
      rd(8'h30, d); chk("R9 busy read", d, 32'h0000_A5C3);
      wr(8'h30, 32'hFFFF_FFFF);
      rd(8'h30, d); chk("R9 busy write ignored", d, 32'h0000_A5C3);
      chan_busy = 16'h0001;
      rd(8'h30, d); chk("R9 busy follows", d, 32'h0000_0001);
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      wr(8'h00, 32'h0000_0005);
      pulse(1, 1);
      wr(8'h08, 32'hFFFF_FFFF);
      wr(8'h18, 32'hFFFF_FFFF);
      wr(8'h20, 32'hFFFF_FFFF);
      rd(8'h08, d); chk("R10 unmapped read 08", d, 0);
      rd(8'h20, d); chk("R10 unmapped read 20", d, 0);
      rd(8'h00, d); chk("R10 en0 untouched", d, 32'h0000_0005);
      rd(8'h04, d); chk("R10 en1 untouched", d, 0);
      rd(8'h10, d); chk("R10 st0 untouched", d, 32'h0000_0020);
      clear_all();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_events();
      t_w1c();
      t_set_wins();
      t_enable_rw();
      t_irq();
      t_busy();
      t_unmapped();
      finish_run();
   end

   initial begin
      #200_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
      finish_run();
   end
endmodule